// File: doc/BRIEF.md
# Four-Product Sum Multiplier

This block multiplies four pairs of small operands and adds the four products into a single 64-bit result. Each pair contributes one product, so the output is the dot product of two four-element vectors. It suits filter taps, small matrix rows and correlators where four narrow multiplications share one adder tree.

A per-sample mode bit selects how the operand bits are read. In unsigned mode, only the low 8 bits of each operand count as an unsigned value. In signed mode, all 9 bits count as a two's complement value. The data passes through four register stages: input capture, products, partial sums, and the output bank. A valid flag travels with each sample, so a new sample can enter on every clock. A synchronous reset empties the pipeline.

Top module: `quad_mac_sum`

## Requirements
- R1: With modeSigned = 0, result equals the sum over lanes 0..3 of xOps[9*i+7 : 9*i] * yOps[9*i+7 : 9*i], with every operand read as unsigned. Lane 0 is the a pair, lane 1 the b pair, lane 2 the c pair and lane 3 the d pair.
- R2: With modeSigned = 1, result equals the sum over lanes of the products of xOps[9*i+8 : 9*i] and yOps[9*i+8 : 9*i], with every operand read as a 9-bit two's complement value.
- R3: modeSigned is captured together with the operands of the same sample. Back-to-back samples may use different modes, and each sample is computed in its own mode.
- R4: The 64-bit result is the exact sum, extended to 64 bits. Bits 63 down to 21 are all copies of the sum's sign: all zeros in unsigned mode and for non-negative signed sums, all ones for negative signed sums.
- R5: A sample presented with inValid high before clock edge k appears on result, with outValid high, just after edge k+3. outValid is inValid delayed by exactly four edges.
- R6: When outValid is low, result keeps the last value it produced.
- R7: Synchronous reset clears result to zero and outValid to 0. Samples that were in flight when reset was asserted never appear at the output.
- R8: In unsigned mode, bit 8 of every operand has no effect on the result.
- R9: A sample may be presented on every clock. Back-to-back samples each produce their own result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Marks the operands and mode on this cycle as a sample |
| modeSigned | input | 1 | 1: 9-bit signed operands; 0: 8-bit unsigned operands |
| xOps | input | 36 | First operand of each lane; lane i occupies bits 9*i+8 : 9*i |
| yOps | input | 36 | Second operand of each lane, same packing as xOps |
| outValid | output | 1 | High when result carries a new sample |
| result | output | 64 | Extended sum of the four products |

## Verification
The bench streams long back-to-back runs of scattered operands in each mode, then a run that flips the mode on every sample. The mixed run shows whether the mode travels with its own sample rather than acting on the whole pipeline. Corner vectors set every lane to the extreme values: 255 unsigned, −256 times −256, and −256 times 255. These expose truncation or a missing sign extension in the upper result bits. Unsigned samples with bit 8 forced high show whether that bit leaks into the product. Idle gaps and a reset issued with samples in flight show the output hold and the flush of the pipeline.

// File: rtl/quad_mac_pkg.sv
package quad_mac_pkg;

  // Load strobes issued by the control path, one for each register stage.
  typedef struct packed {
    logic ldIn;
    logic ldProd;
    logic ldSum;
    logic ldOut;
  } pipeStrobe_t;

endpackage

// File: rtl/quad_mac_ctrl.sv
module quad_mac_ctrl
  import quad_mac_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output pipeStrobe_t strobe,
  output logic        outValid
);

  logic [STAGES-1:0] validPipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      validPipe <= '0;
    end else begin
      validPipe <= {validPipe[STAGES-2:0], inValid};
    end
  end

  // Each stage loads only when the stage in front of it holds a sample.
  always_comb begin
    strobe.ldIn   = inValid;
    strobe.ldProd = validPipe[0];
    strobe.ldSum  = validPipe[1];
    strobe.ldOut  = validPipe[2];
  end

  assign outValid = validPipe[STAGES-1];

endmodule

// File: rtl/quad_mac_datapath.sv
module quad_mac_datapath
  import quad_mac_pkg::*;
#(
  parameter int LANES = 4,
  parameter int OPW   = 9,
  parameter int UW    = 8,
  parameter int RESW  = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  pipeStrobe_t           strobe,
  input  logic                  modeSigned,
  input  logic [LANES*OPW-1:0]  xOps,
  input  logic [LANES*OPW-1:0]  yOps,
  output logic [RESW-1:0]       result
);

  localparam int EXTW  = OPW + 1;
  localparam int PRODW = 2 * EXTW;
  localparam int HALF  = LANES / 2;
  localparam int PAIRW = PRODW + 1;
  localparam int SUMW  = PRODW + $clog2(LANES);

  // Input register bank
  logic [LANES*OPW-1:0] xReg, yReg;
  logic                 modeReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      xReg    <= '0;
      yReg    <= '0;
      modeReg <= 1'b0;
    end else if (strobe.ldIn) begin
      xReg    <= xOps;
      yReg    <= yOps;
      modeReg <= modeSigned;
    end
  end

  // First pipeline stage: one product per lane
  logic signed [PRODW-1:0] prodReg [LANES];

  for (genvar ln = 0; ln < LANES; ln++) begin : gLane
    logic [OPW-1:0]         xRaw, yRaw;
    logic signed [EXTW-1:0] xExt, yExt;
    assign xRaw = xReg[ln*OPW +: OPW];
    assign yRaw = yReg[ln*OPW +: OPW];
    always_comb begin
      if (modeReg) begin
        xExt = {xRaw[OPW-1], xRaw};
        yExt = {yRaw[OPW-1], yRaw};
      end else begin
        xExt = {{(EXTW-UW){1'b0}}, xRaw[UW-1:0]};
        yExt = {{(EXTW-UW){1'b0}}, yRaw[UW-1:0]};
      end
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        prodReg[ln] <= '0;
      end else if (strobe.ldProd) begin
        prodReg[ln] <= xExt * yExt;
      end
    end
  end

  // Second pipeline stage: pairwise partial sums
  logic signed [PAIRW-1:0] pairReg [HALF];

  for (genvar hp = 0; hp < HALF; hp++) begin : gPair
    logic signed [PAIRW-1:0] pairSum;
    assign pairSum = {prodReg[2*hp][PRODW-1], prodReg[2*hp]}
                   + {prodReg[2*hp+1][PRODW-1], prodReg[2*hp+1]};
    always_ff @(posedge clk) begin
      if (rst) begin
        pairReg[hp] <= '0;
      end else if (strobe.ldSum) begin
        pairReg[hp] <= pairSum;
      end
    end
  end

  // Final addition, then the output register bank
  logic signed [SUMW-1:0] total;

  always_comb begin
    total = '0;
    for (int h = 0; h < HALF; h++) begin
      total = total + {{(SUMW-PAIRW){pairReg[h][PAIRW-1]}}, pairReg[h]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
    end else if (strobe.ldOut) begin
      result <= {{(RESW-SUMW){total[SUMW-1]}}, total};
    end
  end

endmodule

// File: rtl/quad_mac_sum.sv
module quad_mac_sum
  import quad_mac_pkg::*;
#(
  parameter int LANES = 4,
  parameter int OPW   = 9,
  parameter int UW    = 8,
  parameter int RESW  = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic                 modeSigned,
  input  logic [LANES*OPW-1:0] xOps,
  input  logic [LANES*OPW-1:0] yOps,
  output logic                 outValid,
  output logic [RESW-1:0]      result
);

  pipeStrobe_t strobe;

  quad_mac_ctrl #(.STAGES(4)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  quad_mac_datapath #(
    .LANES (LANES),
    .OPW   (OPW),
    .UW    (UW),
    .RESW  (RESW)
  ) uPath (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .modeSigned (modeSigned),
    .xOps       (xOps),
    .yOps       (yOps),
    .result     (result)
  );

endmodule

// File: rtl/quad_mac_sum_checker.sv
module quad_mac_sum_checker #(
  parameter int RESW = 64,
  parameter int EXTB = 21
) (
  input logic            clk,
  input logic            rst,
  input logic            inValid,
  input logic            outValid,
  input logic [RESW-1:0] result
);

  logic [2:0] sinceRst;
  logic       rstSeen;

  always_ff @(posedge clk) begin
    rstSeen <= rst;
    if (rst) sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  // R5: outValid trails inValid by exactly four edges
  a_r5_valid_delay: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 3'd4) |-> (outValid == $past(inValid, 4)));

  // R6: result is unchanged while no new sample is presented
  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 3'd2 && !outValid) |-> $stable(result));

  // R7: the edge after reset leaves an empty output
  a_r7_reset_clears: assert property (@(posedge clk)
    rstSeen |-> (result == '0 && !outValid));

  // R4: the upper bits only extend the sign of the sum
  a_r4_pure_extension: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (result[RESW-1:EXTB] == '0 || result[RESW-1:EXTB] == '1));

endmodule

bind quad_mac_sum quad_mac_sum_checker #(.RESW(RESW), .EXTB(21)) uChk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .outValid (outValid),
  .result   (result)
);

// File: tb/tb_quad_mac_sum.sv
`timescale 1ns/1ps
module tb_quad_mac_sum;

  localparam int LANES = 4;
  localparam int OPW   = 9;
  localparam int RESW  = 64;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 inValid = 1'b0;
  logic                 modeSigned = 1'b0;
  logic [LANES*OPW-1:0] xOps = '0;
  logic [LANES*OPW-1:0] yOps = '0;
  logic                 outValid;
  logic [RESW-1:0]      result;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic        ringV [8];
  longint      ringR [8];
  string       ringT [8];
  int          sinceRst = 0;
  longint      holdRes = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  quad_mac_sum dut (
    .clk(clk), .rst(rst), .inValid(inValid), .modeSigned(modeSigned),
    .xOps(xOps), .yOps(yOps), .outValid(outValid), .result(result)
  );

  function automatic longint model(input logic m, input logic [35:0] x,
                                   input logic [35:0] y);
    longint acc = 0;
    for (int i = 0; i < LANES; i++) begin
      longint a, b;
      if (m) begin
        a = longint'($signed(x[i*OPW +: OPW]));
        b = longint'($signed(y[i*OPW +: OPW]));
      end else begin
        a = longint'(x[i*OPW +: 8]);
        b = longint'(y[i*OPW +: 8]);
      end
      acc += a * b;
    end
    return acc;
  endfunction

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One cycle: check the output due now, then drive the next input.
  task automatic step(input logic v, input logic m, input logic [35:0] x,
                      input logic [35:0] y, input string tag);
    logic   expV;
    longint expR;
    string  expT;
    @(negedge clk);
    if (sinceRst >= 4) begin
      expV = ringV[(sinceRst - 4) % 8];
      expR = expV ? ringR[(sinceRst - 4) % 8] : holdRes;
      expT = expV ? ringT[(sinceRst - 4) % 8] : "R6";
    end else begin
      expV = 1'b0;
      expR = holdRes;
      expT = "R7";
    end
    check({expT, " R5 outValid"}, longint'(outValid), longint'(expV));
    check(expT, longint'(result), expR);
    if (expV) holdRes = expR;
    inValid    = v;
    modeSigned = m;
    xOps       = x;
    yOps       = y;
    ringV[sinceRst % 8] = v;
    ringR[sinceRst % 8] = model(m, x, y);
    ringT[sinceRst % 8] = tag;
    sinceRst++;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    sinceRst = 0;
    holdRes = 0;
  endtask

  function automatic logic [35:0] fill(input logic [8:0] v);
    return {v, v, v, v};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    // R7: output idle and zero straight after reset
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, '0, '0, "R7");

    // R1 R9: back-to-back unsigned sweep
    for (int i = 0; i < 2000; i++) begin
      logic [35:0] x, y;
      seed = nextRand(seed); x = {seed[3:0], seed};
      seed = nextRand(seed); y = {seed[7:4], seed};
      for (int l = 0; l < LANES; l++) begin x[l*OPW+8] = 1'b0; y[l*OPW+8] = 1'b0; end
      step(1'b1, 1'b0, x, y, "R1 R9");
    end

    // R2 R4: back-to-back signed sweep
    for (int i = 0; i < 2000; i++) begin
      logic [35:0] x, y;
      seed = nextRand(seed); x = {seed[9:6], seed};
      seed = nextRand(seed); y = {seed[13:10], seed};
      step(1'b1, 1'b1, x, y, "R2 R4");
    end

    // R3: mode flips on every sample
    for (int i = 0; i < 1000; i++) begin
      logic [35:0] x, y;
      seed = nextRand(seed); x = {seed[2:0], seed[0], seed};
      seed = nextRand(seed); y = {seed[5:2], seed};
      step(1'b1, i[0], x, y, "R3");
    end

    // R8: bit 8 set in unsigned mode is ignored
    for (int i = 0; i < 500; i++) begin
      logic [35:0] x, y;
      seed = nextRand(seed); x = seed;
      seed = nextRand(seed); y = seed;
      for (int l = 0; l < LANES; l++) begin x[l*OPW+8] = 1'b1; y[l*OPW+8] = 1'b1; end
      step(1'b1, 1'b0, x, y, "R8");
    end

    // Corner operands
    step(1'b1, 1'b0, fill(9'h0FF), fill(9'h0FF), "R1 max unsigned");
    step(1'b1, 1'b0, fill(9'h1FF), fill(9'h1FF), "R8 max unsigned bit8");
    step(1'b1, 1'b1, fill(9'h100), fill(9'h100), "R2 min*min");
    step(1'b1, 1'b1, fill(9'h100), fill(9'h0FF), "R4 min*max");
    step(1'b1, 1'b1, fill(9'h1FF), fill(9'h001), "R4 minus one");
    step(1'b1, 1'b1, fill(9'h000), fill(9'h100), "R2 zero");
    step(1'b1, 1'b0, fill(9'h100), fill(9'h100), "R8 only bit8");

    // R6: idle gaps between samples hold the result
    for (int i = 0; i < 60; i++) begin
      logic [35:0] x, y;
      seed = nextRand(seed); x = {seed[3:0], seed};
      seed = nextRand(seed); y = {seed[3:0], seed};
      step(i % 3 == 0, seed[20], x, y, "R6 R5");
    end

    // R7: reset with samples in flight flushes them
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, fill(9'h100), fill(9'h0FF), "R7 pre");
    doReset();
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, '0, '0, "R7");
    step(1'b1, 1'b1, fill(9'h1FF), fill(9'h100), "R2 after reset");
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, '0, '0, "R6");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule